// File: doc/BRIEF.md
# Store Queue Commit and Writeback

This block keeps executed stores in a circular buffer until the pipeline retires them, and then sends them in program order to a data cache port. The allocator writes each new store at the tail, together with its sequence number. Execution fills in the store's address, data and byte size later. A commit input carries the youngest retired sequence number. The block flags every matching store as eligible to write back.

A writeback pointer sits between the head and the tail. It offers eligible stores to the cache one at a time over a valid/ready handshake. If the cache refuses a store, the store stays on the port until it is accepted. A store of size zero never reaches the cache and completes immediately. Cache completions return the entry index and may arrive in any order. The head frees an entry only when the oldest entry is complete, and it then moves past every later entry that is already complete. A squash removes uncommitted young stores from the tail.

The queue has one spare slot in addition to its usable entries. The free count it reports is the smaller of the load-queue free count and its own free count, with one subtracted for the spare slot.

Top module: `sq_wb`

## Requirements
- R1: After reset the queue is empty, `alloc_idx` is 0, `req_valid` is low, and `free_count` equals DEPTH when `lq_raw_free` is larger than DEPTH.
- R2: An allocation writes at index `alloc_idx` and moves the tail forward by one slot, wrapping after slot DEPTH. An allocation is ignored when DEPTH stores are held, and it is ignored in any cycle where `squash_valid` is high.
- R3: `free_count` equals min(`lq_raw_free`, DEPTH+1 − held stores) − 1.
- R4: A commit walks forward from the head and flags each unflagged store whose sequence number is at or below `commit_seq`. The walk stops at the first unflagged store that is younger.
- R5: Stores are offered in queue order, one per cycle, only when they are both flagged and executed. A store whose sequence number is above every commit is never offered.
- R6: A flagged, executed store of size 0 raises no request. It is marked complete, and the writeback pointer moves past it in that cycle.
- R7: While `req_valid` is high and `req_ready` is low, the request (index, address, data, size) stays unchanged. The writeback pointer moves only on a handshake.
- R8: A completion (`resp_valid` with `resp_idx`) of a non-head entry frees nothing. Once the head entry is complete, the head moves past it and every following complete entry. The freed space shows in `free_count` one cycle later.
- R9: A squash removes stores from the tail backward while their sequence number is greater than `squash_seq`. It stops at the first flagged store, and the tail moves back to the lowest removed slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| alloc_valid | input | 1 | Allocate a store at the tail |
| alloc_seq | input | SEQ_W | Sequence number of the new store |
| alloc_idx | output | PW | Slot the next allocation will use |
| exec_valid | input | 1 | Execution result for one entry |
| exec_idx | input | PW | Entry being executed |
| exec_addr | input | ADDR_W | Store address |
| exec_data | input | DATA_W | Store data |
| exec_size | input | SIZE_W | Store size in bytes, 0 allowed |
| commit_valid | input | 1 | Commit strobe |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| squash_valid | input | 1 | Squash strobe |
| squash_seq | input | SEQ_W | Stores younger than this are dropped |
| req_valid | output | 1 | Cache write request offered |
| req_ready | input | 1 | Cache accepts the request |
| req_idx | output | PW | Queue index of the request |
| req_addr | output | ADDR_W | Request address |
| req_data | output | DATA_W | Request data |
| req_size | output | SIZE_W | Request size |
| resp_valid | input | 1 | Cache write completion |
| resp_idx | input | PW | Entry that completed |
| lq_raw_free | input | FW | Load-queue free slots including its spare |
| free_count | output | FW | Entries free for dispatch |

## Verification
The assertions check on every cycle that a refused request stays stable and that the writeback index moves after every handshake. They also check that no zero-size request ever reaches the port and that the index and free count stay in range. The ordering behaviours need the bench scenarios. These are: the commit walk stopping at a younger store, zero-size skipping, head movement held back by out-of-order completions, a squash stopping at a committed store, and allocations ignored when the queue is full or a squash is in progress. The scoreboard shows these by comparing the exact sequence of accepted requests and the free count at chosen points.

// File: rtl/sq_wb.sv
module sq_wb #(
  parameter int DEPTH  = 6,
  parameter int SEQ_W  = 16,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int SIZE_W = 4,
  parameter int FW     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_valid,
  input  logic [SEQ_W-1:0]  alloc_seq,
  output logic [$clog2(DEPTH+1)-1:0] alloc_idx,
  input  logic              exec_valid,
  input  logic [$clog2(DEPTH+1)-1:0] exec_idx,
  input  logic [ADDR_W-1:0] exec_addr,
  input  logic [DATA_W-1:0] exec_data,
  input  logic [SIZE_W-1:0] exec_size,
  input  logic              commit_valid,
  input  logic [SEQ_W-1:0]  commit_seq,
  input  logic              squash_valid,
  input  logic [SEQ_W-1:0]  squash_seq,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [$clog2(DEPTH+1)-1:0] req_idx,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  output logic [SIZE_W-1:0] req_size,
  input  logic              resp_valid,
  input  logic [$clog2(DEPTH+1)-1:0] resp_idx,
  input  logic [FW-1:0]     lq_raw_free,
  output logic [FW-1:0]     free_count
);
  localparam int SLOTS = DEPTH + 1;
  localparam int PW    = $clog2(SLOTS);

  logic [PW-1:0]     head, tail, wb, head_n, tail_n, wb_n;
  logic [SLOTS-1:0]  elig, done, exd, elig_n, done_n, exd_n;
  logic [SEQ_W-1:0]  seq_q  [SLOTS];
  logic [ADDR_W-1:0] addr_q [SLOTS];
  logic [DATA_W-1:0] data_q [SLOTS];
  logic [SIZE_W-1:0] size_q [SLOTS];
  logic [PW:0]       cnt, sq_raw;
  logic [FW-1:0]     sq_raw_w;
  logic              wb_live, zero_skip, alloc_ok;

  function automatic logic [PW-1:0] add(input logic [PW-1:0] a, input logic [PW:0] b);
    logic [PW:0] s;
    s = {1'b0, a} + b;
    if (s >= (PW+1)'(SLOTS)) s = s - (PW+1)'(SLOTS);
    return s[PW-1:0];
  endfunction

  assign cnt = (tail >= head) ? {1'b0, tail} - {1'b0, head}
                              : {1'b0, tail} + (PW+1)'(SLOTS) - {1'b0, head};
  assign sq_raw     = (PW+1)'(SLOTS) - cnt;
  assign sq_raw_w   = FW'(sq_raw);
  assign free_count = ((lq_raw_free < sq_raw_w) ? lq_raw_free : sq_raw_w) - FW'(1);

  assign alloc_idx = tail;
  assign alloc_ok  = alloc_valid && !squash_valid && (cnt < (PW+1)'(DEPTH));
  assign wb_live   = (wb != tail) && elig[wb] && exd[wb];
  assign zero_skip = wb_live && (size_q[wb] == '0);
  assign req_valid = wb_live && (size_q[wb] != '0);
  assign req_idx   = wb;
  assign req_addr  = addr_q[wb];
  assign req_data  = data_q[wb];
  assign req_size  = size_q[wb];

  always_comb begin
    logic          run;
    logic [PW-1:0] ix;
    elig_n = elig;
    done_n = done;
    exd_n  = exd;
    head_n = head;
    tail_n = tail;
    wb_n   = wb;
    run    = 1'b1;
    ix     = '0;
    if (exec_valid) exd_n[exec_idx] = 1'b1;
    if (resp_valid) done_n[resp_idx] = 1'b1;
    if (zero_skip) begin
      done_n[wb] = 1'b1;
      wb_n = add(wb, (PW+1)'(1));
    end else if (req_valid && req_ready) begin
      wb_n = add(wb, (PW+1)'(1));
    end
    if (commit_valid) begin
      run = 1'b1;
      for (int i = 0; i < SLOTS; i++) begin
        ix = add(head, (PW+1)'(i));
        if (run && ((PW+1)'(i) < cnt) && !elig[ix]) begin
          if (seq_q[ix] <= commit_seq) elig_n[ix] = 1'b1;
          else run = 1'b0;
        end
      end
    end
    run = 1'b1;
    for (int i = 0; i < SLOTS; i++) begin
      ix = add(head, (PW+1)'(i));
      if (run && ((PW+1)'(i) < cnt) && done[ix]) head_n = add(head, (PW+1)'(i + 1));
      else run = 1'b0;
    end
    if (squash_valid) begin
      run = 1'b1;
      for (int i = SLOTS - 1; i >= 0; i--) begin
        if (run && ((PW+1)'(i) < cnt)) begin
          ix = add(head, (PW+1)'(i));
          if (seq_q[ix] > squash_seq && !elig[ix]) tail_n = ix;
          else run = 1'b0;
        end
      end
    end
    if (alloc_ok) begin
      tail_n       = add(tail, (PW+1)'(1));
      elig_n[tail] = 1'b0;
      done_n[tail] = 1'b0;
      exd_n[tail]  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head <= '0;
      tail <= '0;
      wb   <= '0;
      elig <= '0;
      done <= '0;
      exd  <= '0;
    end else begin
      head <= head_n;
      tail <= tail_n;
      wb   <= wb_n;
      elig <= elig_n;
      done <= done_n;
      exd  <= exd_n;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_ok) seq_q[tail] <= alloc_seq;
    if (exec_valid) begin
      addr_q[exec_idx] <= exec_addr;
      data_q[exec_idx] <= exec_data;
      size_q[exec_idx] <= exec_size;
    end
  end
endmodule

// File: rtl/sq_wb_chk.sv
module sq_wb_chk #(
  parameter int SLOTS  = 7,
  parameter int PW     = 3,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int SIZE_W = 4,
  parameter int FW     = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [PW-1:0]     req_idx,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_data,
  input logic [SIZE_W-1:0] req_size,
  input logic [PW-1:0]     alloc_idx,
  input logic [FW-1:0]     free_count
);
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> req_valid && $stable(req_idx) && $stable(req_addr)
                                && $stable(req_data) && $stable(req_size));

  a_r5_advance: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !req_valid || (req_idx != $past(req_idx)));

  a_r6_no_zero: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> req_size != '0);

  a_r2_idx_range: assert property (@(posedge clk) disable iff (rst)
    alloc_idx < PW'(SLOTS) && req_idx < PW'(SLOTS));

  a_r3_free_bound: assert property (@(posedge clk) disable iff (rst)
    free_count <= FW'(SLOTS - 1));
endmodule

bind sq_wb sq_wb_chk #(
  .SLOTS(SLOTS), .PW(PW), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W), .FW(FW)
) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_idx(req_idx), .req_addr(req_addr), .req_data(req_data), .req_size(req_size),
  .alloc_idx(alloc_idx), .free_count(free_count)
);

// File: tb/sq_wb_tb_top.sv
module sq_wb_tb_top;
  localparam int DEPTH = 6, SEQ_W = 16, ADDR_W = 32, DATA_W = 64, SIZE_W = 4, FW = 5;
  localparam int PW = $clog2(DEPTH + 1);

  typedef struct packed {
    logic [ADDR_W-1:0] a;
    logic [DATA_W-1:0] d;
    logic [SIZE_W-1:0] s;
  } item_t;

  logic clk = 0, rst = 1;
  logic alloc_valid = 0, exec_valid = 0, commit_valid = 0, squash_valid = 0;
  logic req_ready = 1, resp_valid = 0, req_valid;
  logic [SEQ_W-1:0] alloc_seq = 0, commit_seq = 0, squash_seq = 0;
  logic [PW-1:0] alloc_idx, exec_idx = 0, req_idx, resp_idx = 0;
  logic [ADDR_W-1:0] exec_addr = 0, req_addr;
  logic [DATA_W-1:0] exec_data = 0, req_data;
  logic [SIZE_W-1:0] exec_size = 0, req_size;
  logic [FW-1:0] lq_raw_free = 16, free_count;

  int checks = 0, errors = 0;
  item_t sb[$];

  always #5 clk = ~clk;

  sq_wb #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
          .SIZE_W(SIZE_W), .FW(FW)) dut_i (
    .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_seq(alloc_seq),
    .alloc_idx(alloc_idx), .exec_valid(exec_valid), .exec_idx(exec_idx),
    .exec_addr(exec_addr), .exec_data(exec_data), .exec_size(exec_size),
    .commit_valid(commit_valid), .commit_seq(commit_seq),
    .squash_valid(squash_valid), .squash_seq(squash_seq),
    .req_valid(req_valid), .req_ready(req_ready), .req_idx(req_idx),
    .req_addr(req_addr), .req_data(req_data), .req_size(req_size),
    .resp_valid(resp_valid), .resp_idx(resp_idx),
    .lq_raw_free(lq_raw_free), .free_count(free_count));

  function automatic logic [ADDR_W-1:0] addr_of(input int s);
    return ADDR_W'(32'h1000 + s * 16);
  endfunction
  function automatic logic [DATA_W-1:0] data_of(input int s);
    return {16'hA5A5, 16'(s), 16'h5A5A, 16'(s * 3)};
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic do_alloc(input int s, output logic [PW-1:0] idx);
    alloc_valid = 1; alloc_seq = SEQ_W'(s); idx = alloc_idx;
    tick(); alloc_valid = 0;
  endtask

  task automatic do_exec(input logic [PW-1:0] idx, input int s, input int sz, input bit expect_req);
    exec_valid = 1; exec_idx = idx; exec_addr = addr_of(s); exec_data = data_of(s);
    exec_size = SIZE_W'(sz);
    if (expect_req) sb.push_back('{a: addr_of(s), d: data_of(s), s: SIZE_W'(sz)});
    tick(); exec_valid = 0;
  endtask

  task automatic do_commit(input int s);
    commit_valid = 1; commit_seq = SEQ_W'(s); tick(); commit_valid = 0;
  endtask

  task automatic do_squash(input int s);
    squash_valid = 1; squash_seq = SEQ_W'(s); tick(); squash_valid = 0;
  endtask

  task automatic do_resp(input logic [PW-1:0] idx);
    resp_valid = 1; resp_idx = idx; tick(); resp_valid = 0;
  endtask

  // scoreboard monitor: handshake seen mid-cycle, completes at next edge
  always @(negedge clk) begin
    if (!rst && req_valid && req_ready) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R5 unexpected request actual=%0h expected=none", req_addr);
      end else begin
        item_t e;
        e = sb.pop_front();
        if (e.a !== req_addr || e.d !== req_data || e.s !== req_size) begin
          errors++;
          $display("FAIL R5 request actual=%0h/%0h/%0d expected=%0h/%0h/%0d",
                   req_addr, req_data, req_size, e.a, e.d, e.s);
        end
      end
    end
  end

  task automatic report;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    logic [PW-1:0] i0, i1, i2, i3, i4, i5, t0, tmp;
    tick(3);
    rst = 0;
    tick();
    chk("R1 free", free_count, 6);
    chk("R1 req_valid", req_valid, 0);
    chk("R1 alloc_idx", alloc_idx, 0);

    // in-order send, zero-size skip, commit stop, out-of-order completion
    req_ready = 1;
    do_alloc(10, i0); do_alloc(11, i1); do_alloc(12, i2);
    chk("R2 idx0", i0, 0); chk("R2 idx1", i1, 1); chk("R2 idx2", i2, 2);
    tick();
    chk("R3 free after 3", free_count, 3);
    do_exec(i0, 10, 4, 1); do_exec(i1, 11, 0, 0); do_exec(i2, 12, 8, 1);
    do_commit(11);
    tick(5);
    chk("R4 younger held", sb.size(), 1);
    chk("R4 no request", req_valid, 0);
    do_commit(12);
    tick(5);
    chk("R5 all sent", sb.size(), 0);
    chk("R8 nothing freed yet", free_count, 3);
    do_resp(i2);
    tick(3);
    chk("R8 ooo completion holds head", free_count, 3);
    do_resp(i0);
    tick(3);
    chk("R6 R8 head runs past zero-size and done", free_count, 6);

    // refused request held
    req_ready = 0;
    do_alloc(20, i3); do_alloc(21, i4);
    do_exec(i3, 20, 2, 1); do_exec(i4, 21, 2, 1);
    do_commit(21);
    tick(4);
    chk("R7 offered", req_valid, 1);
    chk("R7 addr", req_addr, addr_of(20));
    chk("R7 idx", req_idx, 3);
    tick(3);
    chk("R7 still same", req_addr, addr_of(20));
    req_ready = 1;
    tick(4);
    chk("R7 drained", sb.size(), 0);
    do_resp(i4); do_resp(i3);
    tick(3);
    chk("R8 freed", free_count, 6);

    // squash
    req_ready = 0;
    do_alloc(30, i0); do_alloc(31, i1); do_alloc(32, i2); do_alloc(33, i5);
    chk("R2 wrap", i2, 0);
    do_exec(i0, 30, 4, 1); do_exec(i1, 31, 4, 1); do_exec(i2, 32, 4, 0); do_exec(i5, 33, 4, 0);
    do_commit(31);
    do_squash(31);
    tick(3);
    chk("R9 two dropped", free_count, 4);
    do_squash(29);
    tick(3);
    chk("R9 stops at committed", free_count, 4);
    do_alloc(34, tmp);
    chk("R9 tail rolled back", tmp, 0);
    do_squash(33);
    tick(3);
    chk("R9 squash new", free_count, 4);
    req_ready = 1;
    tick(5);
    chk("R9 only committed sent", sb.size(), 0);
    do_resp(i0); do_resp(i1);
    tick(3);
    chk("R8 freed after squash", free_count, 6);

    // load queue limit, full queue, alloc during squash
    lq_raw_free = 3;
    tick();
    chk("R3 lq limits", free_count, 2);
    lq_raw_free = 16;
    t0 = alloc_idx;
    for (int k = 0; k < 6; k++) do_alloc(40 + k, tmp);
    tick();
    chk("R3 full", free_count, 0);
    tmp = alloc_idx;
    do_alloc(46, i0);
    tick();
    chk("R2 full ignored free", free_count, 0);
    chk("R2 full ignored idx", alloc_idx, tmp);
    alloc_valid = 1; alloc_seq = 50;
    do_squash(39);
    alloc_valid = 0;
    tick(2);
    chk("R2 squash wins free", free_count, 6);
    chk("R2 squash wins idx", alloc_idx, t0);
    tick(3);
    chk("R5 no stray", sb.size(), 0);
    report();
  end
endmodule